// File: doc/BRIEF.md
# 64-bit Comparator Timer

This block keeps a free-running 64-bit up-counter and compares it with a 64-bit match value. When the counter is at or beyond the match value and matching is switched on, a sticky event flag is raised. It drives a level interrupt for as long as the flag is set and the interrupt is allowed. For periodic events, an optional step value is added to the match value on every hit, so the next event falls one period later without any software action.

Software reaches the block through a plain 32-bit register port with byte offsets. Writes take effect at the clock edge on which `sel_i` and `we_i` are both high. Read data is combinational from `addr_i`. The port has no handshake and never stalls, so no back-pressure exists anywhere in the block.

The counter is seen as two 32-bit halves. Software obtains a coherent 64-bit value by reading the upper half, then the lower half, then the upper half again, and retrying if the two upper reads differ.

Top module: `cmp_timer64`

## Requirements
- R1: Registers decode on `addr_i[4:2]` at these byte offsets:
  - 0x00: counter low half.
  - 0x04: counter high half.
  - 0x08: control.
  - 0x0C: status.
  - 0x10: match low half.
  - 0x14: match high half.
  - 0x18: step value.
  Each readable register returns its current value.
- R2: While control bit 0 is clear, a write to either counter half loads that half, and the counter otherwise holds its value.
- R3: While control bit 0 is set, the counter rises by exactly one per clock, and the carry passes from the low half into the high half. If the two high-half reads of an upper-lower-upper sequence match, the value read is coherent.
- R4: While control bit 0 is set, writes to the counter halves are ignored.
- R5: While control bit 1 is set and counter >= match value (an unsigned 64-bit comparison), status bit 0 is set at the next clock edge. A counter already past the match value also sets it.
- R6: While control bit 1 is clear, status bit 0 is never set, including when the match halves are written.
- R7: Writing 1 to status bit 0 clears it. Writing 0 to it has no effect.
- R8: A hit in the same cycle as a clearing write leaves status bit 0 set.
- R9: `irq_o` is high exactly when status bit 0 and control bit 2 are both set.
- R10: While control bit 3 is set, every hit adds the 32-bit step value, zero-extended, to the 64-bit match value. A software write to a match half in the same cycle takes precedence over the addition.
- R11: Control bits 31:4 read as zero, and offset 0x1C reads as zero.
- R12: After reset, every register, the flag and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, with `sel_i` |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker watches the following properties on every cycle:
- single-step counting while enabled;
- holding while disabled;
- flag set after any greater-or-equal hit;
- flag never set with matching off;
- stickiness until a clearing write;
- interrupt low without the flag;
- the step addition on each hit.

Some behaviours are only visible at the register port, so only the bench scenarios can show them:
- the address decode;
- preload and readback;
- writes ignored while counting;
- coherent upper-lower-upper reads across a carry;
- the final match value after a run of auto-step hits from random start points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int IDX_CNT_LO = 0;
  localparam int IDX_CNT_HI = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_STAT   = 3;
  localparam int IDX_CMP_LO = 4;
  localparam int IDX_CMP_HI = 5;
  localparam int IDX_STEP   = 6;

  localparam int CTRL_W     = 4;
  localparam int BIT_RUN    = 0;
  localparam int BIT_MATCH  = 1;
  localparam int BIT_IRQ    = 2;
  localparam int BIT_STEP   = 3;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + CW'(1);
    end else begin
      if (wr_lo_i) cnt_q[DW-1:0]  <= wdata_i;
      if (wr_hi_i) cnt_q[CW-1:DW] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          match_en_i,
  input  logic          step_en_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_step_i,
  input  logic          clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cmp_o,
  output logic [DW-1:0] step_o,
  output logic          flag_o
);
  logic [CW-1:0] cmp_q;
  logic [DW-1:0] step_q;
  logic          flag_q;
  logic          hit;

  assign hit = match_en_i && (cnt_i >= cmp_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cmp_q[DW-1:0]  <= wdata_i;
      if (wr_hi_i) cmp_q[CW-1:DW] <= wdata_i;
    end else if (hit && step_en_i) begin
      cmp_q <= cmp_q + CW'(step_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        step_q <= '0;
    else if (wr_step_i) step_q <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cmp_o  = cmp_q;
  assign step_o = step_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
  import tmr_pkg::*;
#(
  parameter int CW = 64,
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int IW = AW - 2;

  logic [IW-1:0]     widx;
  logic              wr;
  logic [CTRL_W-1:0] ctrl;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     cmp;
  logic [DW-1:0]     step;
  logic              flag;
  logic              wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_step, clr;

  assign widx      = addr_i[AW-1:2];
  assign wr        = sel_i && we_i;
  assign wr_cnt_lo = wr && (widx == IW'(IDX_CNT_LO));
  assign wr_cnt_hi = wr && (widx == IW'(IDX_CNT_HI));
  assign wr_cmp_lo = wr && (widx == IW'(IDX_CMP_LO));
  assign wr_cmp_hi = wr && (widx == IW'(IDX_CMP_HI));
  assign wr_step   = wr && (widx == IW'(IDX_STEP));
  assign clr       = wr && (widx == IW'(IDX_STAT)) && wdata_i[0];

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                          ctrl <= '0;
    else if (wr && widx == IW'(IDX_CTRL)) ctrl <= wdata_i[CTRL_W-1:0];
  end

  tmr_counter #(.CW(CW), .DW(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl[BIT_RUN]),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  tmr_match #(.CW(CW), .DW(DW)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .match_en_i (ctrl[BIT_MATCH]),
    .step_en_i  (ctrl[BIT_STEP]),
    .wr_lo_i    (wr_cmp_lo),
    .wr_hi_i    (wr_cmp_hi),
    .wr_step_i  (wr_step),
    .clr_i      (clr),
    .wdata_i    (wdata_i),
    .cmp_o      (cmp),
    .step_o     (step),
    .flag_o     (flag)
  );

  always_comb begin
    case (widx)
      IW'(IDX_CNT_LO): rdata_o = cnt[DW-1:0];
      IW'(IDX_CNT_HI): rdata_o = cnt[CW-1:DW];
      IW'(IDX_CTRL):   rdata_o = DW'(ctrl);
      IW'(IDX_STAT):   rdata_o = DW'(flag);
      IW'(IDX_CMP_LO): rdata_o = cmp[DW-1:0];
      IW'(IDX_CMP_HI): rdata_o = cmp[CW-1:DW];
      IW'(IDX_STEP):   rdata_o = step;
      default:         rdata_o = '0;
    endcase
  end

  assign irq_o = flag && ctrl[BIT_IRQ];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp,
  input logic [DW-1:0] step,
  input logic          flag,
  input logic          run,
  input logic          match_en,
  input logic          step_en,
  input logic          cnt_wr,
  input logic          cmp_wr,
  input logic          clr,
  input logic          irq
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> cnt == $past(cnt) + CW'(1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_wr) |=> $stable(cnt)); // R2
  AST_HIT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_en && cnt >= cmp) |=> flag); // R5
  AST_NO_SET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && !match_en) |=> !flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !clr) |=> flag); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag |-> !irq); // R9
  AST_STEP_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_en && step_en && cnt >= cmp && !cmp_wr)
      |=> cmp == $past(cmp) + CW'($past(step))); // R10
endmodule

bind cmp_timer64 tmr_checker #(.CW(CW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt      (cnt),
  .cmp      (cmp),
  .step     (step),
  .flag     (flag),
  .run      (ctrl[0]),
  .match_en (ctrl[1]),
  .step_en  (ctrl[3]),
  .cnt_wr   (wr_cnt_lo || wr_cnt_hi),
  .cmp_wr   (wr_cmp_lo || wr_cmp_hi),
  .clr      (clr),
  .irq      (irq_o)
);

// File: tb/test_cmp_timer64.sv
`timescale 1ns/1ps
module test_cmp_timer64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer64 i_cmp_timer64 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; sel = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1; d = rdata; sel = 0;
  endtask

  function automatic logic [63:0] exp_cmp(logic [63:0] c, logic [63:0] m, logic [31:0] s);
    while (c >= m) m = m + 64'(s);
    return m;
  endfunction

  task automatic rd64(input logic [4:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 5'd4, hi);
    v = {hi, lo};
  endtask

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, h1, h2;
    logic [63:0] v, c0, m0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R12 reset state, R1 readback of zeroed map
    for (int i = 0; i < 7; i++) begin
      rd(5'(i*4), d); chk("R12", d, 0);
    end
    chk("R12 irq", irq, 0);

    // R11 unmapped offset and unused control bits
    rd(5'h1C, d); chk("R11 unmapped", d, 0);
    wr(5'h08, 32'hFFFF_FFF0); rd(5'h08, d); chk("R11 ctrl upper", d, 0);

    // R2 preload while disabled, R1 readback
    wr(5'h00, 32'hFFFF_FFFC); wr(5'h04, 32'h0000_0005);
    rd64(5'h00, v); chk("R2 preload", v, 64'h5_FFFF_FFFC);
    repeat (5) @(posedge clk);
    rd64(5'h00, v); chk("R2 hold", v, 64'h5_FFFF_FFFC);

    // R3 exact count with carry: 10 increments
    wr(5'h08, 32'h1);
    repeat (9) @(posedge clk);
    wr(5'h08, 32'h0);
    rd64(5'h00, v); chk("R3 count carry", v, 64'h6_0000_0006);

    // R4 counter write ignored while running: 2 increments
    wr(5'h08, 32'h1); wr(5'h00, 32'h0000_1234); wr(5'h08, 32'h0);
    rd64(5'h00, v); chk("R4 write ignored", v, 64'h6_0000_0008);

    // R3 upper-lower-upper coherence across carry
    wr(5'h00, 32'hFFFF_FFF8); wr(5'h04, 32'h7); wr(5'h08, 32'h1);
    for (int k = 0; k < 8; k++) begin
      rd(5'h04, h1); rd(5'h00, d); rd(5'h04, h2);
      if (h1 == h2)
        chk("R3 coherent", (h1 == 7 && d >= 32'hFFFF_FFF8) || (h1 == 8 && d < 32'h40), 1);
    end
    wr(5'h08, 32'h0);

    // R6 match writes with match off do not set flag
    wr(5'h00, 32'd100); wr(5'h04, 0);
    wr(5'h10, 32'd50); wr(5'h14, 0);
    repeat (3) @(posedge clk);
    rd(5'h0C, d); chk("R6 no flag", d, 0);

    // R5 greater-or-equal hit, R9 irq gated off
    wr(5'h08, 32'h2);
    repeat (2) @(posedge clk);
    rd(5'h0C, d); chk("R5 ge hit", d, 1);
    chk("R9 irq gated", irq, 0);
    wr(5'h08, 32'h6); @(negedge clk);
    chk("R9 irq on", irq, 1);

    // R8 clear during continuing hit keeps flag
    wr(5'h0C, 32'h1); rd(5'h0C, d); chk("R8 hit wins", d, 1);

    // R7 write 0 no effect, write 1 clears
    wr(5'h08, 32'h4);
    wr(5'h0C, 32'h0); rd(5'h0C, d); chk("R7 write zero", d, 1);
    wr(5'h0C, 32'h1); rd(5'h0C, d); chk("R7 clear", d, 0);
    chk("R9 irq low", irq, 0);
    wr(5'h08, 32'h0);

    // R10 directed step
    wr(5'h10, 32'd90); wr(5'h18, 32'd20); wr(5'h08, 32'hA);
    repeat (4) @(posedge clk);
    rd64(5'h10, v); chk("R10 step", v, 64'd110);
    rd(5'h18, d); chk("R1 step readback", d, 20);
    wr(5'h0C, 32'h1); wr(5'h08, 32'h0);

    // R10 random step runs
    for (int it = 0; it < 8; it++) begin
      logic [31:0] s;
      c0 = {1'b0, 31'($urandom) | 31'h1, $urandom};
      m0 = c0 - 64'($urandom % 201);
      s  = 32'(1 + $urandom % 64);
      wr(5'h00, c0[31:0]); wr(5'h04, c0[63:32]);
      wr(5'h10, m0[31:0]); wr(5'h14, m0[63:32]); wr(5'h18, s);
      wr(5'h08, 32'hA);
      repeat (300) @(posedge clk);
      rd64(5'h10, v); chk("R10 random step", v, exp_cmp(c0, m0, s));
      rd(5'h0C, d); chk("R5 random flag", d, 1);
      wr(5'h0C, 32'h1); wr(5'h08, 32'h0);
      rd(5'h0C, d); chk("R7 random clear", d, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule